// File: doc/BRIEF.md
# Transfer Request Descriptor Builder

This block turns a short command request into the eight-word transfer request descriptor that a flash-storage host controller fetches from its request list. A request carries the data direction, the transfer length in bytes, the 64-bit base address of the command descriptor area, and an optional scatter-entry count that takes the place of the default count. The block holds the request and emits the descriptor one 32-bit little-endian word at a time, lowest address first, on a valid/ready stream. A DMA writer or list manager downstream stores the words.

The command descriptor area is laid out in fixed aligned units. The command packet comes first, the response packet sits one unit in, and the scatter table sits two units in. The block works out all offsets and lengths in 4-byte words from the parameter `UNIT_BYTES`. It preloads the status field with the "invalid" code, which the controller overwrites when the command completes. Only one descriptor is in flight at a time.

Top module: `tdb_builder`

## Requirements
- R1: After reset `out_valid` is 0 and `req_ready` is 1.
- R2: A request is taken on a cycle where `req_valid` and `req_ready` are both 1. From that cycle until the eighth word is accepted, `req_ready` is 0. Request inputs presented during that time have no effect on the words emitted.
- R3: Exactly eight words are emitted per request, in ascending word order 0..7. `out_last` is 1 only on word 7. While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold. The cycle after word 7 is accepted, `out_valid` is 0 and `req_ready` is 1.
- R4: Word 0 is 0x11000000 (command type 1 in bits 31:28, interrupt-on-completion bit 24) ORed with a direction code. The `req_dir` encoding is 0 = no data, 1 = host-to-device, 2 = device-to-host, and 3 is treated as no data. Host-to-device gives code 0x02000000, device-to-host gives 0x04000000, and no data gives 0.
- R5: Words 1 and 3 are zero.
- R6: Word 2 is 0x0000000F: the invalid-status code in bits 3:0, all other bits clear.
- R7: Word 4 is `req_base[31:0]` and word 5 is `req_base[63:32]`.
- R8: Word 6 has the response offset, UNIT_BYTES/4, in bits 31:16 and the response length, UNIT_BYTES/4, in bits 15:0. With the default UNIT_BYTES of 512 this is 0x00800080.
- R9: Word 7 has the scatter table offset, 2*UNIT_BYTES/4, in bits 31:16. Bits 15:0 hold the scatter entry count. When `req_cnt_ovr` is 1 the count is `req_cnt`. Otherwise it is 1 when `req_len` is non-zero and 0 when `req_len` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Builder idle, request can be taken |
| req_dir | input | 2 | Data direction code |
| req_len | input | 32 | Transfer length in bytes |
| req_base | input | 64 | Command descriptor base address |
| req_cnt_ovr | input | 1 | Use `req_cnt` as the scatter entry count |
| req_cnt | input | 16 | Replacement scatter entry count |
| out_valid | output | 1 | Descriptor word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 32 | Descriptor word, little-endian value |
| out_last | output | 1 | Final word of the descriptor |

## Verification
The assertions assume that `out_ready` may drop at any time and that `req_valid` may stay high while the block is busy. They make no assumption that requests are well formed. Direction code 3 and any override count are legal inputs. The stimulus stalls the output at random and keeps `req_valid` asserted, with scrambled fields, through each descriptor. It releases `req_valid` in the same cycle the last word is accepted, so every request taken is one the bench intended to send.

// File: rtl/tdb_pkg.sv
package tdb_pkg;

    localparam int TDB_WORDS   = 8;
    localparam int TDB_IDX_W   = $clog2(TDB_WORDS);

    localparam logic [31:0] HDR_CMD_TYPE   = 32'h1000_0000;
    localparam logic [31:0] HDR_IRQ_DONE   = 32'h0100_0000;
    localparam logic [31:0] HDR_DIR_H2D    = 32'h0200_0000;
    localparam logic [31:0] HDR_DIR_D2H    = 32'h0400_0000;
    localparam logic [31:0] STAT_INVALID   = 32'h0000_000F;

    typedef enum logic [1:0] {
        XDIR_NONE = 2'd0,
        XDIR_H2D  = 2'd1,
        XDIR_D2H  = 2'd2,
        XDIR_RSVD = 2'd3
    } xfer_dir_e;

    typedef struct packed {
        xfer_dir_e    dir;
        logic [31:0]  len;
        logic [63:0]  base;
        logic         cnt_ovr;
        logic [15:0]  cnt;
    } tdb_req_t;

    function automatic logic [31:0] dir_bits(input xfer_dir_e d);
        case (d)
            XDIR_H2D: return HDR_DIR_H2D;
            XDIR_D2H: return HDR_DIR_D2H;
            default:  return 32'h0;
        endcase
    endfunction

    function automatic logic [15:0] bytes_to_dw(input int unsigned nbytes);
        return 16'(nbytes >> 2);
    endfunction

    function automatic logic [15:0] sg_count(input tdb_req_t r);
        if (r.cnt_ovr)
            return r.cnt;
        return (r.len != 32'd0) ? 16'd1 : 16'd0;
    endfunction

endpackage

// File: rtl/tdb_req_hold.sv
module tdb_req_hold
    import tdb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  tdb_req_t req_in,
    output tdb_req_t req_q
);
    always_ff @(posedge clk) begin
        if (rst)
            req_q <= '0;
        else if (load)
            req_q <= req_in;
    end
endmodule

// File: rtl/tdb_seq.sv
module tdb_seq #(
    parameter int WORDS = 8,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             out_ready,
    output logic             busy,
    output logic [IDX_W-1:0] idx,
    output logic             last,
    output logic             fire
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    assign last = busy && (idx == LAST_IDX);
    assign fire = busy && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                idx  <= '0;
            end
        end else if (fire) begin
            if (idx == LAST_IDX) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tdb_word_mux.sv
module tdb_word_mux
    import tdb_pkg::*;
#(
    parameter int UNIT_BYTES = 512
) (
    input  tdb_req_t               req,
    input  logic [TDB_IDX_W-1:0]   idx,
    output logic [31:0]            word
);
    localparam logic [15:0] RSP_OFF_DW = bytes_to_dw(UNIT_BYTES);
    localparam logic [15:0] RSP_LEN_DW = bytes_to_dw(UNIT_BYTES);
    localparam logic [15:0] SG_OFF_DW  = bytes_to_dw(2 * UNIT_BYTES);

    always_comb begin
        case (idx)
            3'd0:    word = HDR_CMD_TYPE | HDR_IRQ_DONE | dir_bits(req.dir);
            3'd2:    word = STAT_INVALID;
            3'd4:    word = req.base[31:0];
            3'd5:    word = req.base[63:32];
            3'd6:    word = {RSP_OFF_DW, RSP_LEN_DW};
            3'd7:    word = {SG_OFF_DW, sg_count(req)};
            default: word = 32'h0;
        endcase
    end
endmodule

// File: rtl/tdb_builder.sv
module tdb_builder
    import tdb_pkg::*;
#(
    parameter int UNIT_BYTES = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_dir,
    input  logic [31:0] req_len,
    input  logic [63:0] req_base,
    input  logic        req_cnt_ovr,
    input  logic [15:0] req_cnt,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data,
    output logic        out_last
);
    tdb_req_t               req_in;
    tdb_req_t               req_q;
    logic                   busy;
    logic                   take;
    logic                   fire;
    logic [TDB_IDX_W-1:0]   idx;

    assign req_in = '{dir: xfer_dir_e'(req_dir), len: req_len, base: req_base,
                      cnt_ovr: req_cnt_ovr, cnt: req_cnt};
    assign req_ready = !busy;
    assign take      = req_valid && !busy;
    assign out_valid = busy;

    tdb_req_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (take),
        .req_in (req_in),
        .req_q  (req_q)
    );

    tdb_seq #(.WORDS(TDB_WORDS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (take),
        .out_ready (out_ready),
        .busy      (busy),
        .idx       (idx),
        .last      (out_last),
        .fire      (fire)
    );

    tdb_word_mux #(.UNIT_BYTES(UNIT_BYTES)) u_mux (
        .req  (req_q),
        .idx  (idx),
        .word (out_data)
    );
endmodule

// File: rtl/tdb_builder_chk.sv
module tdb_builder_chk #(
    parameter int UNIT_BYTES = 512
) (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_last
);
    localparam logic [31:0] W6 = {16'(UNIT_BYTES / 4), 16'(UNIT_BYTES / 4)};

    logic [2:0] seen;
    always_ff @(posedge clk) begin
        if (rst)
            seen <= '0;
        else if (out_valid && out_ready)
            seen <= out_last ? 3'd0 : seen + 3'd1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!out_valid && req_ready)); // R1
    AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !req_ready); // R2
    AST_TAKE_STARTS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (out_valid && seen == 3'd0)); // R2
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R3
    AST_LAST_POS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (seen == 3'd7))); // R3
    AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (!out_valid && req_ready)); // R3
    AST_STATUS_INIT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen == 3'd2) |-> (out_data == 32'h0000_000F)); // R6
    AST_RSP_WORD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen == 3'd6) |-> (out_data == W6)); // R8
endmodule

bind tdb_builder tdb_builder_chk #(.UNIT_BYTES(UNIT_BYTES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/tdb_builder_tb.sv
module tdb_builder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT = 512;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_dir;
    logic [31:0] req_len;
    logic [63:0] req_base;
    logic        req_cnt_ovr;
    logic [15:0] req_cnt;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_data;
    logic        out_last;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdb_builder #(.UNIT_BYTES(UNIT)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_dir(req_dir), .req_len(req_len), .req_base(req_base),
        .req_cnt_ovr(req_cnt_ovr), .req_cnt(req_cnt),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    function automatic logic [31:0] exp_word(input logic [1:0] d, input logic [31:0] len,
                                             input logic [63:0] base, input logic ovr,
                                             input logic [15:0] cnt, input int i);
        logic [31:0] dc;
        logic [15:0] n;
        dc = (d == 2'd1) ? 32'h0200_0000 : (d == 2'd2) ? 32'h0400_0000 : 32'h0;
        n  = ovr ? cnt : ((len != 0) ? 16'd1 : 16'd0);
        case (i)
            0: return 32'h1100_0000 | dc;
            2: return 32'h0000_000F;
            4: return base[31:0];
            5: return base[63:32];
            6: return {16'(UNIT/4), 16'(UNIT/4)};
            7: return {16'(2*UNIT/4), n};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int i);
        case (i)
            0: return "R4";
            1, 3: return "R5";
            2: return "R6";
            4, 5: return "R7";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] d, input logic [31:0] len, input logic [63:0] base,
                        input logic ovr, input logic [15:0] cnt);
        int n = 0;
        int guard = 0;
        @(negedge clk);
        req_valid = 1'b1; req_dir = d; req_len = len; req_base = base;
        req_cnt_ovr = ovr; req_cnt = cnt; out_ready = 1'b0;
        #1;
        check(req_ready === 1'b1, "R2 ready before take", 64'(req_ready), 64'd1);
        while (n < 8 && guard < 200) begin
            guard++;
            @(negedge clk);
            // scramble the request inputs while busy: must have no effect (R2)
            req_dir = 2'($urandom); req_len = $urandom; req_base = {$urandom, $urandom};
            req_cnt_ovr = 1'($urandom); req_cnt = 16'($urandom);
            out_ready = ($urandom % 4) != 0;
            #1;
            check(req_ready === 1'b0, "R2 ready low while busy", 64'(req_ready), 64'd0);
            if (out_valid && out_ready) begin
                check(out_data === exp_word(d, len, base, ovr, cnt, n), tag_of(n),
                      64'(out_data), 64'(exp_word(d, len, base, ovr, cnt, n)));
                check(out_last === (n == 7), "R3 last flag", 64'(out_last), 64'(n == 7));
                n++;
                if (n == 8) req_valid = 1'b0;
            end
        end
        check(n == 8, "R3 word count", 64'(n), 64'd8);
        @(negedge clk);
        #1;
        check(out_valid === 1'b0 && req_ready === 1'b1, "R3 idle after last",
              {out_valid, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; req_valid = 1'b0; req_dir = 0; req_len = 0; req_base = 0;
        req_cnt_ovr = 0; req_cnt = 0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        check(out_valid === 1'b0 && req_ready === 1'b1, "R1 reset state",
              {out_valid, req_ready}, 2'b01);
        // hold: no request, stays idle
        repeat (2) @(negedge clk);
        check(out_valid === 1'b0, "R1 idle without request", 64'(out_valid), 64'd0);

        send(2'd0, 32'd0,          64'h0,                  1'b0, 16'd0);  // R4 none, R9 len zero
        send(2'd1, 32'd4096,       64'h0000_0001_2345_6400, 1'b0, 16'd0); // R4 h2d
        send(2'd2, 32'd1,          64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 16'd0); // R4 d2h, R7 all ones
        send(2'd3, 32'hFFFF_FFFF,  64'hDEAD_BEEF_CAFE_0000, 1'b0, 16'd0); // R4 reserved as none
        send(2'd1, 32'd8192,       64'h10,                  1'b1, 16'd0); // R9 override to zero
        send(2'd2, 32'd0,          64'h20,                  1'b1, 16'hFFFF); // R9 override max
        for (int k = 0; k < 40; k++)
            send(2'($urandom), (($urandom % 4) == 0) ? 32'd0 : $urandom,
                 {$urandom, $urandom}, 1'($urandom), 16'($urandom));

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule